// File: doc/BRIEF.md
# Banked Program Counter Sequencer

This block drives the program counter of a small 4-bit controller whose program memory is organised as two banks of 32 pages, each page holding 64 words. In every instruction cycle (one clock) it receives a decoded instruction class with its operands. From these it computes the next ROM address: the bank bit, the 5-bit page within the bank and the 6-bit word address. It also keeps a four-level hardware return stack for subroutines. The status flag and a bank-select register bit come from outside as plain inputs.

Branches do not carry a page number. They take the page from a preload register. A separate preload instruction writes that register, and the new value is seen by the next instruction. A bank-retention rule limits the branches: code running in bank 1 cannot branch into bank 0 except through the long branch. A subroutine call always enters page 0 of bank 0. A fifth nested call drops the oldest return address and raises a sticky overflow flag.

The ROM address is presented as `rom_addr = {bank, page[4:0], word[5:0]}`, so `rom_addr[11:6]` is the absolute page. Bank 1 page n is absolute page n+32.

Top module: `bpc_sequencer`

## Requirements
- R1: A synchronous active-high `rst` sets `rom_addr` to 0, the preload register to 0, the stack depth to 0 and clears `stack_ovf`. As a result, a taken branch with no preload lands in absolute page 0.
- R2: `op` = 0 (step) and `op` = 7 (idle) add 1 to the word field modulo 64. Bank and page stay unchanged, including when the word field wraps from 63 to 0.
- R3: `op` = 1 (preload) stores the 6-bit absolute page `pg_operand` and steps the word field. The stored value is used by the branch in the following instruction cycle and by any later branch, until the next preload.
- R4: `op` = 2 (short branch) with `flag_in` = 1 loads the word field from `addr_operand` and the page from the preload register. The new bank is the current bank OR the preload bank bit, so code in bank 1 stays in bank 1. With `flag_in` = 0 the instruction steps as in R2.
- R5: `op` = 3 (bank-test branch) branches whatever `flag_in` holds. The new bank is 1 if the current bank is 1, and otherwise follows `p2`. The page comes from the preload register and the word from `addr_operand`.
- R6: `op` = 4 (long branch) branches unconditionally. The new bank is 0 when `bank_sel` = 1 and 1 when `bank_sel` = 0. The page comes from the preload bits [4:0] and the word from `addr_operand`.
- R7: `op` = 5 (call) sets the bank and page to 0 and the word to `addr_operand`. It pushes the stepped address (same bank and page, word+1 modulo 64) onto the top of the stack and shifts each older entry down one level.
- R8: `op` = 6 (return) loads the top entry into `rom_addr` and shifts the lower entries up one level. The bottom level keeps its old value.
- R9: Four nested calls followed by four returns restore the four return addresses in last-in, first-out order.
- R10: A call made while four entries are held discards the oldest entry and sets `stack_ovf`. The flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one instruction cycle per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 3 | Instruction class: 0 step, 1 preload, 2 short branch, 3 bank-test branch, 4 long branch, 5 call, 6 return, 7 idle |
| addr_operand | input | 6 | Target word for branches and calls |
| pg_operand | input | 6 | Absolute page for preload (bit 5 = bank) |
| p2 | input | 1 | Bank operand of the bank-test branch |
| flag_in | input | 1 | Status flag qualifying the short branch |
| bank_sel | input | 1 | Bank-select register bit for the long branch |
| rom_addr | output | 12 | Current ROM address {bank, page, word} |
| stack_ovf | output | 1 | Sticky return-stack overflow flag |

## Verification
The case that is hardest to reach from the ports is a fifth nested call, and a return taken after the oldest entry has been lost. Uniform random classes keep calls and returns roughly balanced, so the stack depth rarely reaches four. The stimulus therefore mixes directed nesting sequences with random bursts of back-to-back calls. Preload-then-branch pairs are also forced in bank 1, to exercise the retention rule against a bank-0 preload.

// File: rtl/bpc_pkg.sv
package bpc_pkg;
  typedef enum logic [2:0] {
    OP_STEP    = 3'd0,
    OP_PRELOAD = 3'd1,
    OP_BR      = 3'd2,
    OP_TBR     = 3'd3,
    OP_BRL     = 3'd4,
    OP_CALL    = 3'd5,
    OP_RET     = 3'd6,
    OP_IDLE    = 3'd7
  } op_t;
endpackage

// File: rtl/bpc_next.sv
module bpc_next #(
  parameter int AW = 6,
  parameter int PW = 5,
  localparam int PCW = 1 + PW + AW
) (
  input  logic [2:0]     op,
  input  logic [PCW-1:0] cur_pc,
  input  logic [PW:0]    pre_page,
  input  logic [AW-1:0]  addr_operand,
  input  logic           p2,
  input  logic           flag_in,
  input  logic           bank_sel,
  input  logic [PCW-1:0] stack_top,
  output logic [PCW-1:0] nxt_pc,
  output logic [PCW-1:0] ret_pc,
  output logic           push,
  output logic           pop
);
  import bpc_pkg::*;

  function automatic logic [PCW-1:0] step_of(input logic [PCW-1:0] pc);
    return {pc[PCW-1:AW], pc[AW-1:0] + AW'(1)};
  endfunction

  function automatic logic [PCW-1:0] jump_of(input logic bank, input logic [PW-1:0] pg,
                                             input logic [AW-1:0] wd);
    return {bank, pg, wd};
  endfunction

  logic cur_bank;
  assign cur_bank = cur_pc[PCW-1];
  assign ret_pc   = step_of(cur_pc);

  always_comb begin
    nxt_pc = step_of(cur_pc);
    push   = 1'b0;
    pop    = 1'b0;
    unique case (op_t'(op))
      OP_BR:   if (flag_in) nxt_pc = jump_of(cur_bank | pre_page[PW], pre_page[PW-1:0], addr_operand);
      OP_TBR:  nxt_pc = jump_of(cur_bank | p2, pre_page[PW-1:0], addr_operand);
      OP_BRL:  nxt_pc = jump_of(~bank_sel, pre_page[PW-1:0], addr_operand);
      OP_CALL: begin
        nxt_pc = jump_of(1'b0, '0, addr_operand);
        push   = 1'b1;
      end
      OP_RET: begin
        nxt_pc = stack_top;
        pop    = 1'b1;
      end
      default: nxt_pc = step_of(cur_pc);
    endcase
  end
endmodule

// File: rtl/bpc_stack.sv
module bpc_stack #(
  parameter int DEPTH = 4,
  parameter int W = 12,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] push_data,
  output logic [W-1:0] top,
  output logic         full,
  output logic         ovf
);
  logic [W-1:0]  ent [DEPTH];
  logic [CW-1:0] depth;

  assign top  = ent[0];
  assign full = (depth == CW'(DEPTH));

  for (genvar i = 0; i < DEPTH; i++) begin : g_lvl
    always_ff @(posedge clk) begin
      if (rst) ent[i] <= '0;
      else if (push) ent[i] <= (i == 0) ? push_data : ent[(i == 0) ? 0 : i - 1];
      else if (pop && i < DEPTH - 1) ent[i] <= ent[(i < DEPTH - 1) ? i + 1 : i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      depth <= '0;
      ovf   <= 1'b0;
    end else if (push) begin
      if (full) ovf <= 1'b1;
      else depth <= depth + CW'(1);
    end else if (pop && depth != '0) begin
      depth <= depth - CW'(1);
    end
  end
endmodule

// File: rtl/bpc_sequencer.sv
module bpc_sequencer #(
  parameter int ADDR_W = 6,
  parameter int PAGE_W = 5,
  parameter int STACK_DEPTH = 4,
  localparam int PCW = 1 + PAGE_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        op,
  input  logic [ADDR_W-1:0] addr_operand,
  input  logic [PAGE_W:0]   pg_operand,
  input  logic              p2,
  input  logic              flag_in,
  input  logic              bank_sel,
  output logic [PCW-1:0]    rom_addr,
  output logic              stack_ovf
);
  import bpc_pkg::*;

  logic [PCW-1:0]  pc_q, pc_d, ret_pc, stack_top;
  logic [PAGE_W:0] pre_q;
  logic            do_push, do_pop, stack_full;

  bpc_next #(.AW(ADDR_W), .PW(PAGE_W)) u_next (
    .op(op), .cur_pc(pc_q), .pre_page(pre_q), .addr_operand(addr_operand),
    .p2(p2), .flag_in(flag_in), .bank_sel(bank_sel), .stack_top(stack_top),
    .nxt_pc(pc_d), .ret_pc(ret_pc), .push(do_push), .pop(do_pop)
  );

  bpc_stack #(.DEPTH(STACK_DEPTH), .W(PCW)) u_stack (
    .clk(clk), .rst(rst), .push(do_push), .pop(do_pop), .push_data(ret_pc),
    .top(stack_top), .full(stack_full), .ovf(stack_ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      pre_q <= '0;
    end else begin
      pc_q <= pc_d;
      if (op_t'(op) == OP_PRELOAD) pre_q <= pg_operand;
    end
  end

  assign rom_addr = pc_q;
endmodule

// File: rtl/bpc_checker.sv
module bpc_checker #(
  parameter int PCW = 12,
  parameter int AW = 6
) (
  input logic           clk,
  input logic           rst,
  input logic [2:0]     op,
  input logic [AW-1:0]  addr_operand,
  input logic           bank_sel,
  input logic           flag_in,
  input logic [PCW-1:0] rom_addr,
  input logic           stack_ovf,
  input logic           do_push,
  input logic           do_pop,
  input logic           stack_full
);
  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    (op == 3'd0) |=> (rom_addr[PCW-1:AW] == $past(rom_addr[PCW-1:AW]) &&
                      rom_addr[AW-1:0] == $past(rom_addr[AW-1:0]) + AW'(1)));

  assert_br_keep_bank1_R4: assert property (@(posedge clk) disable iff (rst)
    (op == 3'd2 && rom_addr[PCW-1]) |=> rom_addr[PCW-1]);

  assert_tbr_keep_bank1_R5: assert property (@(posedge clk) disable iff (rst)
    (op == 3'd3 && rom_addr[PCW-1]) |=> rom_addr[PCW-1]);

  assert_brl_bank_R6: assert property (@(posedge clk) disable iff (rst)
    (op == 3'd4) |=> (rom_addr[PCW-1] == !$past(bank_sel)));

  assert_call_target_R7: assert property (@(posedge clk) disable iff (rst)
    (op == 3'd5) |=> (rom_addr[PCW-1:AW] == '0 && rom_addr[AW-1:0] == $past(addr_operand)));

  assert_push_pop_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(do_push && do_pop));

  assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    stack_ovf |=> stack_ovf);

  assert_ovf_cause_R10: assert property (@(posedge clk) disable iff (rst)
    (do_push && stack_full) |=> stack_ovf);
endmodule

bind bpc_sequencer bpc_checker #(.PCW(PCW), .AW(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .op(op), .addr_operand(addr_operand), .bank_sel(bank_sel),
  .flag_in(flag_in), .rom_addr(rom_addr), .stack_ovf(stack_ovf),
  .do_push(do_push), .do_pop(do_pop), .stack_full(stack_full)
);

// File: tb/tb_bpc_sequencer.sv
module tb_bpc_sequencer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  op = 3'd0;
  logic [5:0]  addr_operand = '0;
  logic [5:0]  pg_operand = '0;
  logic        p2 = 1'b0, flag_in = 1'b0, bank_sel = 1'b0;
  logic [11:0] rom_addr;
  logic        stack_ovf;

  int checks = 0, failures = 0;

  // reference state
  logic [11:0] m_pc, m_st [4];
  logic [5:0]  m_pre;
  int          m_depth;
  logic        m_ovf;

  always #10 clk = ~clk;

  bpc_sequencer dut (
    .clk(clk), .rst(rst), .op(op), .addr_operand(addr_operand), .pg_operand(pg_operand),
    .p2(p2), .flag_in(flag_in), .bank_sel(bank_sel), .rom_addr(rom_addr), .stack_ovf(stack_ovf)
  );

  function automatic logic [11:0] after_step(input logic [11:0] pc);
    logic [5:0] w = pc[5:0] + 6'd1;
    return {pc[11:6], w};
  endfunction

  task automatic model_reset();
    m_pc = '0; m_pre = '0; m_depth = 0; m_ovf = 1'b0;
    for (int i = 0; i < 4; i++) m_st[i] = '0;
  endtask

  task automatic model_apply();
    logic [11:0] old = m_pc;
    case (op)
      3'd1: begin m_pc = after_step(old); m_pre = pg_operand; end
      3'd2: m_pc = flag_in ? {old[11] | m_pre[5], m_pre[4:0], addr_operand} : after_step(old);
      3'd3: m_pc = {old[11] | p2, m_pre[4:0], addr_operand};
      3'd4: m_pc = {!bank_sel, m_pre[4:0], addr_operand};
      3'd5: begin
        m_st[3] = m_st[2]; m_st[2] = m_st[1]; m_st[1] = m_st[0];
        m_st[0] = after_step(old);
        if (m_depth == 4) m_ovf = 1'b1; else m_depth++;
        m_pc = {6'd0, addr_operand};
      end
      3'd6: begin
        m_pc = m_st[0];
        m_st[0] = m_st[1]; m_st[1] = m_st[2]; m_st[2] = m_st[3];
        if (m_depth > 0) m_depth--;
      end
      default: m_pc = after_step(old);
    endcase
  endtask

  task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a negedge: drive, update model, wait one cycle, compare
  task automatic issue(input string tag, input logic [2:0] o, input logic [5:0] a,
                       input logic [5:0] pg, input logic fl, input logic pp, input logic bs);
    op = o; addr_operand = a; pg_operand = pg; flag_in = fl; p2 = pp; bank_sel = bs;
    model_apply();
    @(negedge clk);
    check(tag, rom_addr, m_pc);
    check({tag, "_ovf"}, {11'd0, stack_ovf}, {11'd0, m_ovf});
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0; op = 3'd7;
    model_reset();
    check("R1_reset_pc", rom_addr, 12'd0);
    check("R1_reset_ovf", {11'd0, stack_ovf}, 12'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int burst;
    logic [2:0] o;
    model_reset();
    @(negedge clk);
    do_reset();
    issue("R1_preload_zero", 3'd2, 6'd5, 6'd0, 1, 0, 0);
    issue("R2_step_to63", 3'd2, 6'd63, 6'd0, 1, 0, 0);
    issue("R2_wrap", 3'd0, 0, 0, 0, 0, 0);
    issue("R2_idle", 3'd7, 0, 0, 0, 0, 0);
    issue("R3_preload_steps", 3'd1, 6'd9, 6'd15, 1, 0, 0);
    issue("R3_next_branch_uses", 3'd2, 6'h3F, 0, 1, 0, 0);
    issue("R4_not_taken", 3'd2, 6'd1, 0, 0, 0, 0);
    issue("R3_pre_b1", 3'd1, 0, 6'd47, 0, 0, 0);
    issue("R6_brl_bank0", 3'd4, 6'd3, 0, 0, 0, 1);
    issue("R6_brl_bank1", 3'd4, 6'd4, 0, 0, 0, 0);
    issue("R3_pre_b0", 3'd1, 0, 6'd5, 0, 0, 0);
    issue("R4_stay_bank1", 3'd2, 6'd7, 0, 1, 0, 0);
    issue("R5_tbr_b1_flag0", 3'd3, 6'd8, 0, 0, 0, 0);
    issue("R6_back_b0", 3'd4, 6'd9, 0, 0, 0, 1);
    issue("R5_tbr_b0_p2_0", 3'd3, 6'd10, 0, 0, 0, 0);
    issue("R5_tbr_b0_p2_1", 3'd3, 6'd11, 0, 0, 1, 0);
    issue("R6_back_b0b", 3'd4, 6'd12, 0, 0, 0, 1);
    issue("R3_pre_b1b", 3'd1, 0, 6'd40, 0, 0, 0);
    issue("R4_b0_to_b1", 3'd2, 6'd13, 0, 1, 0, 0);
    for (int i = 0; i < 4; i++) issue("R7_call", 3'd5, 6'(20 + i), 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) issue("R9_ret_lifo", 3'd6, 0, 0, 0, 0, 0);
    issue("R8_ret_empty", 3'd6, 0, 0, 0, 0, 0);
    for (int i = 0; i < 5; i++) issue("R10_call5", 3'd5, 6'(30 + i), 0, 0, 0, 0);
    for (int i = 0; i < 5; i++) issue("R10_ret_after_ovf", 3'd6, 0, 0, 0, 0, 0);
    issue("R10_sticky", 3'd0, 0, 0, 0, 0, 0);
    do_reset();
    void'($urandom(32'd4242));
    burst = 0;
    for (int n = 0; n < 4000; n++) begin
      if (burst > 0) begin o = 3'd5; burst--; end
      else begin
        o = 3'($urandom_range(0, 7));
        if ($urandom_range(0, 60) == 0) burst = $urandom_range(3, 6);
      end
      if (n == 2000) do_reset();
      issue(o == 3'd5 ? "R7_rand" : o == 3'd6 ? "R8_rand" : o == 3'd2 ? "R4_rand" :
            o == 3'd3 ? "R5_rand" : o == 3'd4 ? "R6_rand" : o == 3'd1 ? "R3_rand" : "R2_rand",
            o, 6'($urandom), 6'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule